// File: doc/BRIEF.md
# Program Flow Unit with Vectored Calls and Loop Counters

This unit holds the instruction pointer of a small processor core, together with an interrupt vector register and two loop counters. The pointer leaves reset at 8000h, moves forward by one on every fetch strobe, and can be redirected from four places. A direct register write makes a jump. An interrupt acknowledge makes a call to the stored vector. A decrement-and-branch request on either loop counter makes a loop branch. When none of these is active and there is no fetch, the pointer holds.

Each cycle a small arbiter picks one pointer action in fixed priority order. ACT_VECTOR (interrupt call) comes first, then ACT_JUMP (direct write), then ACT_LOOP (loop branch taken), then ACT_STEP (fetch increment), and ACT_HOLD last. The action chosen in a cycle sets the pointer value at the next clock edge. Every action can follow every other one; no action needs more than one cycle.

On an interrupt call the unit raises a push request toward an external stack in that same cycle. The request carries the current pointer as the return address. The instruction memory and the stack storage sit outside this block.

Top module: `flow_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the pointer reads 8000h, and the vector register and both loop counters read 0000h.
- R2: A fetch strobe with no higher-priority action adds one to the pointer at the next edge, wrapping from FFFFh to 0000h.
- R3: A register write with select 0 loads the pointer with the written data at the next edge, and it wins over a fetch in the same cycle.
- R4: A cycle with no fetch, no pointer write, no interrupt acknowledge and no loop request leaves the pointer unchanged, whatever the read select is.
- R5: The read port returns, in the same cycle, the pointer for select 0, the vector for select 1, loop counter 0 for select 2 and loop counter 1 for select 3. A register write with the same select codes updates the vector or a counter at the next edge.
- R6: An interrupt acknowledge raises push_req in the same cycle with push_data equal to the current pointer. At the next edge the pointer takes the vector value held before that edge. This beats a pointer write, a loop branch and a fetch in the same cycle.
- R7: A loop request decrements only the counter chosen by djnz_sel (0 or 1) by one, wrapping from 0000h to FFFFh.
- R8: A loop request is taken (djnz_taken high in the same cycle, pointer equal to djnz_target at the next edge) when the decremented value is nonzero. When it is not taken, the pointer follows the fetch strobe.
- R9: A pointer write in the same cycle as a taken loop request wins over the loop target.
- R10: A register write to a loop counter in the same cycle as a loop request on that counter stores the written value. The branch decision still uses the old value minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch | input | 1 | Program fetch strobe |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Write select: 0 pointer, 1 vector, 2 counter 0, 3 counter 1 |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read select, same codes as wr_sel |
| rd_data | output | 16 | Selected register value |
| int_ack | input | 1 | Interrupt acknowledge |
| djnz_req | input | 1 | Loop decrement-and-branch request |
| djnz_sel | input | 1 | Loop counter select |
| djnz_target | input | 16 | Loop branch target |
| djnz_taken | output | 1 | Loop branch will be taken this cycle |
| push_req | output | 1 | Push the return address onto the stack |
| push_data | output | 16 | Return address to push |
| pc | output | 16 | Current instruction pointer |

## Verification
Three outputs are combinational views of the current cycle: push_req with push_data, djnz_taken, and rd_data. The bench checks them one nanosecond after it drives the inputs, before the next rising edge. The pointer and every written or decremented register change at the first rising edge after the stimulus. The bench therefore updates its behavioural model at that edge and compares the pointer at the following falling edge. Register contents are read through rd_data at the start of the next step. Collisions such as an acknowledge with a pointer write, or a counter write with a loop request, are applied in one cycle so that the priority order decides a single next value.

// File: rtl/flow_pkg.sv
package flow_pkg;
    localparam int ADDR_W  = 16;
    localparam int NUM_LC  = 2;
    localparam int LCS_W   = (NUM_LC > 1) ? $clog2(NUM_LC) : 1;
    localparam int SEL_W   = 2;
    localparam int LC_BASE = 2;
    localparam logic [ADDR_W-1:0] RESET_VEC = 16'h8000;

    typedef enum logic [SEL_W-1:0] {
        SEL_IP  = 2'd0,
        SEL_IV  = 2'd1,
        SEL_LC0 = 2'd2,
        SEL_LC1 = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ACT_HOLD   = 3'd0,
        ACT_STEP   = 3'd1,
        ACT_LOOP   = 3'd2,
        ACT_JUMP   = 3'd3,
        ACT_VECTOR = 3'd4
    } pc_act_e;
endpackage

// File: rtl/flow_arbiter.sv
module flow_arbiter
    import flow_pkg::*;
(
    input  logic    int_ack,
    input  logic    ip_wr,
    input  logic    loop_taken,
    input  logic    fetch,
    output pc_act_e act
);
    always_comb begin
        if (int_ack)          act = ACT_VECTOR;
        else if (ip_wr)       act = ACT_JUMP;
        else if (loop_taken)  act = ACT_LOOP;
        else if (fetch)       act = ACT_STEP;
        else                  act = ACT_HOLD;
    end
endmodule

// File: rtl/flow_loop_ctr.sv
module flow_loop_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         branch
);
    logic [W-1:0] dec_val;

    assign dec_val = count - W'(1);
    // branch decision compares in parallel with the subtractor
    assign branch  = (count != W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= load_val;
        else if (dec)   count <= dec_val;
    end
endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl
    import flow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              int_ack,
    input  logic              djnz_req,
    input  logic [LCS_W-1:0]  djnz_sel,
    input  logic [ADDR_W-1:0] djnz_target,
    output logic              djnz_taken,
    output logic              push_req,
    output logic [ADDR_W-1:0] push_data,
    output logic [ADDR_W-1:0] pc
);
    logic [ADDR_W-1:0] pc_q, pc_d;
    logic [ADDR_W-1:0] iv_q;
    logic [ADDR_W-1:0] lc_val [NUM_LC];
    logic [NUM_LC-1:0] lc_br;
    logic              ip_wr, iv_wr;
    pc_act_e           act;

    assign ip_wr = wr_en && (wr_sel == SEL_W'(SEL_IP));
    assign iv_wr = wr_en && (wr_sel == SEL_W'(SEL_IV));

    for (genvar g = 0; g < NUM_LC; g++) begin : g_lc
        logic ld, dc;
        assign ld = wr_en && (wr_sel == SEL_W'(LC_BASE + g));
        assign dc = djnz_req && (djnz_sel == LCS_W'(g));
        flow_loop_ctr #(.W(ADDR_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld),
            .load_val (wr_data),
            .dec      (dc),
            .count    (lc_val[g]),
            .branch   (lc_br[g])
        );
    end

    assign djnz_taken = djnz_req && lc_br[djnz_sel];

    flow_arbiter u_arb (
        .int_ack    (int_ack),
        .ip_wr      (ip_wr),
        .loop_taken (djnz_taken),
        .fetch      (fetch),
        .act        (act)
    );

    always_comb begin
        unique case (act)
            ACT_VECTOR: pc_d = iv_q;
            ACT_JUMP:   pc_d = wr_data;
            ACT_LOOP:   pc_d = djnz_target;
            ACT_STEP:   pc_d = pc_q + ADDR_W'(1);
            ACT_HOLD:   pc_d = pc_q;
            default:    pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= RESET_VEC;
        else        pc_q <= pc_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      iv_q <= '0;
        else if (iv_wr)  iv_q <= wr_data;
    end

    assign push_req  = int_ack;
    assign push_data = pc_q;
    assign pc        = pc_q;

    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_W'(SEL_IP)) rd_data = pc_q;
        if (rd_sel == SEL_W'(SEL_IV)) rd_data = iv_q;
        for (int g = 0; g < NUM_LC; g++) begin
            if (rd_sel == SEL_W'(LC_BASE + g)) rd_data = lc_val[g];
        end
    end
endmodule

// File: rtl/flow_ctrl_chk.sv
module flow_ctrl_chk
    import flow_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              fetch,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [ADDR_W-1:0] wr_data,
    input logic              int_ack,
    input logic              djnz_req,
    input logic [LCS_W-1:0]  djnz_sel,
    input logic [ADDR_W-1:0] djnz_target,
    input logic              djnz_taken,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] iv_q,
    input logic [ADDR_W-1:0] lc_val [NUM_LC]
);
    logic ipw;
    assign ipw = wr_en && (wr_sel == SEL_W'(SEL_IP));

    AST_RESET_VECTOR: assert property (@(posedge clk)
        $rose(rst_n) |-> (pc == RESET_VEC)); // R1

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !int_ack && !ipw && !djnz_taken) |=> (pc == $past(pc) + 16'd1)); // R2

    AST_WRITE_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (ipw && !int_ack) |=> (pc == $past(wr_data))); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch && !ipw && !int_ack && !djnz_req) |=> $stable(pc)); // R4

    AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> (pc == $past(iv_q))); // R6

    AST_LOOP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (djnz_req && djnz_sel == LCS_W'(0) && !(wr_en && wr_sel == SEL_W'(SEL_LC0)))
        |=> (lc_val[0] == $past(lc_val[0]) - 16'd1)); // R7

    AST_LOOP_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (djnz_taken && !int_ack && !ipw) |=> (pc == $past(djnz_target))); // R8
endmodule

bind flow_ctrl flow_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch       (fetch),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .int_ack     (int_ack),
    .djnz_req    (djnz_req),
    .djnz_sel    (djnz_sel),
    .djnz_target (djnz_target),
    .djnz_taken  (djnz_taken),
    .pc          (pc),
    .iv_q        (iv_q),
    .lc_val      (lc_val)
);

// File: tb/flow_ctrl_tb.sv
`timescale 1ns/1ps
module flow_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch = 1'b0, wr_en = 1'b0, int_ack = 1'b0, djnz_req = 1'b0;
    logic [1:0]  wr_sel = '0, rd_sel = '0;
    logic [15:0] wr_data = '0, djnz_target = '0;
    logic [0:0]  djnz_sel = '0;
    logic [15:0] rd_data, push_data, pc;
    logic        djnz_taken, push_req;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int m_pc, m_iv;
    int m_lc [2];

    always #2.5 clk = ~clk;

    flow_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fetch(fetch), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .int_ack(int_ack),
        .djnz_req(djnz_req), .djnz_sel(djnz_sel), .djnz_target(djnz_target),
        .djnz_taken(djnz_taken), .push_req(push_req), .push_data(push_data), .pc(pc)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, check same-cycle outputs, advance model, check pointer
    task automatic step(string tag, bit f, bit we, int ws, int wd, bit ack,
                        bit dj, int ds, int dt, int rs);
        int nl, exp_rd, npc;
        bit tk;
        fetch = f; wr_en = we; wr_sel = 2'(ws); wr_data = 16'(wd); int_ack = ack;
        djnz_req = dj; djnz_sel = 1'(ds); djnz_target = 16'(dt); rd_sel = 2'(rs);
        #1;
        nl = (m_lc[ds] - 1) & 32'hFFFF;
        tk = dj && (nl != 0);
        case (rs)
            0: exp_rd = m_pc;
            1: exp_rd = m_iv;
            2: exp_rd = m_lc[0];
            default: exp_rd = m_lc[1];
        endcase
        chk(tag, "rd_data", int'(rd_data), exp_rd);
        chk(tag, "djnz_taken", int'(djnz_taken), int'(tk));
        chk(tag, "push_req", int'(push_req), int'(ack));
        if (ack) chk(tag, "push_data", int'(push_data), m_pc);
        if (ack)                  npc = m_iv;
        else if (we && ws == 0)   npc = wd;
        else if (tk)              npc = dt;
        else if (f)               npc = (m_pc + 1) & 32'hFFFF;
        else                      npc = m_pc;
        @(posedge clk);
        m_pc = npc;
        if (we && ws == 1) m_iv = wd;
        if (dj) m_lc[ds] = nl;
        if (we && ws >= 2) m_lc[ws - 2] = wd;
        @(negedge clk);
        chk(tag, "pc", int'(pc), m_pc);
    endtask

    task automatic idle(string tag, int rs);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, rs);
    endtask

    initial begin
        m_pc = 32'h8000; m_iv = 0; m_lc[0] = 0; m_lc[1] = 0;
        repeat (3) @(negedge clk);
        chk("R1", "pc in reset", int'(pc), 32'h8000);
        rst_n = 1'b1;
        // R1 reset values read back
        idle("R1", 0); idle("R1", 1); idle("R1", 2); idle("R1", 3);
        // R2 fetch increments
        for (int i = 0; i < 3; i++) step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3 write beats fetch, then R2 wrap
        step("R3", 1, 1, 0, 32'hFFFF, 0, 0, 0, 0, 0);
        step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R4 reads only
        idle("R4", 1); idle("R4", 2); idle("R4", 0);
        // R5 writes and readback
        step("R5", 0, 1, 1, 32'h1234, 0, 0, 0, 0, 1);
        step("R5", 0, 1, 2, 3, 0, 0, 0, 0, 1);
        step("R5", 0, 1, 3, 1, 0, 0, 0, 0, 2);
        idle("R5", 3);
        // R8 taken loops on counter 0 then fall-through
        step("R8", 1, 0, 0, 0, 0, 1, 0, 32'h0100, 2);
        step("R8", 1, 0, 0, 0, 0, 1, 0, 32'h0100, 2);
        step("R8", 1, 0, 0, 0, 0, 1, 0, 32'h0100, 2);
        // R7 wrap 0 -> FFFF, counter 1 untouched
        step("R7", 1, 0, 0, 0, 0, 1, 0, 32'h0200, 3);
        idle("R7", 2); idle("R7", 3);
        // R8 not taken on counter 1 without fetch: hold
        step("R8", 0, 0, 0, 0, 0, 1, 1, 32'h0300, 3);
        idle("R7", 3);
        // R9 pointer write beats taken loop
        step("R9", 1, 1, 0, 32'h4000, 0, 1, 0, 32'h0500, 2);
        // R6 acknowledge beats write, fetch and loop; vector written same cycle is not used
        step("R6", 1, 1, 0, 32'h7777, 1, 1, 0, 32'h0600, 0);
        step("R6", 1, 1, 1, 32'hABCD, 1, 0, 0, 0, 1);
        step("R6", 0, 0, 0, 0, 1, 0, 0, 0, 1);
        // R10 counter write with loop request on same counter
        step("R10", 1, 1, 3, 5, 0, 1, 1, 32'h0700, 3);
        idle("R10", 3);
        step("R10", 0, 1, 2, 1, 0, 1, 0, 32'h0800, 2);
        idle("R10", 2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule